// File: doc/BRIEF.md
# Speculative Load Conflict Table

This block tracks loads that a compiler or scheduler has moved above earlier stores. When such a load issues early, it enters its destination register number and its address into a small fully associative table. Every store that follows is compared with all live entries. A store to the same 32-bit word removes the matching entries, so the table remembers that the early value may be stale.

At the point where the load originally stood in program order, a check names the destination register. One cycle later the block reports whether the load has to be run again (`chk_replay` high) or whether the early value may be kept (`chk_replay` low). A check always uses up its entry. When the table is full, a new entry takes over a slot chosen round-robin. A check whose entry was pushed out this way, or never existed, reports a replay. That answer errs on the safe side. The load/store datapath and the replay itself are handled outside the block.

Top module: `ldspec_guard`

## Requirements
- R1: `chk_done` is high in exactly the cycle after a cycle with `chk_valid` high, and low otherwise; `chk_replay` is never high while `chk_done` is low.
- R2: A check on a register whose entry was inserted earlier, and not hit by any store since, returns `chk_replay` = 0.
- R3: Addresses match when bits [ADDR_W-1:2] are equal; bits [1:0] are ignored. A store that matches an entry removes it, so a later check on that register replays. A single store removes every entry it matches. A store to a different word leaves entries alone.
- R4: A check consumes its entry: a second check on the same register without a new insertion returns `chk_replay` = 1.
- R5: There is at most one entry per register. Inserting again for a register that already has an entry overwrites that entry's address, so a store to the old address no longer causes a conflict.
- R6: A check on a register that has no entry returns `chk_replay` = 1.
- R7: A new register takes the lowest free slot. When no slot is free, it takes the slot named by a round-robin pointer that starts at slot 0 after reset and advances by one only on such a takeover. A check on the displaced register returns `chk_replay` = 1.
- R8: A store whose word equals the word of an insertion in the same cycle counts as a conflict for that entry. A store that matches the entry being checked in the same cycle makes that check return `chk_replay` = 1.
- R9: Synchronous active-high `rst` empties the table and drives `chk_done` and `chk_replay` low.
- R10: A check and an insertion for the same register in the same cycle work as follows: the check answers from the old entry, and the new entry stays for a later check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Record an early load this cycle |
| ins_reg | input | REG_W | Destination register of the early load |
| ins_addr | input | ADDR_W | Byte address of the early load |
| st_valid | input | 1 | A store is seen this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Query the table at the load's home position |
| chk_reg | input | REG_W | Register being checked |
| chk_done | output | 1 | Registered: a check answer is present |
| chk_replay | output | 1 | Registered: the checked load must be run again |

## Verification
The bench uses the default parameters: NUM_ENT=4, REG_W=5 and ADDR_W=32. With only four slots, four insertions fill the table. The fifth and sixth insertions then exercise round-robin takeover and the pointer stepping to its next slot. The 32-bit address leaves room to place stores in the same word with different byte offsets, and in neighbouring words. The 5-bit register field gives more distinct registers than there are slots. The same-cycle cases are driven on purpose: store with insertion, store with check, and check with insertion.

// File: rtl/ldspec_pkg.sv
package ldspec_pkg;

  // Byte-offset bits dropped before any address comparison.
  localparam int WORD_LSB = 2;

  // Where an insertion lands.
  typedef enum logic [1:0] {
    PICK_SAME  = 2'd0,  // register already present: overwrite its slot
    PICK_FREE  = 2'd1,  // lowest invalid slot
    PICK_EVICT = 2'd2   // table full: round-robin victim
  } pick_e;

endpackage

// File: rtl/ldspec_cmp.sv
// Compare logic for one table slot: register and word-address match.
module ldspec_cmp #(
  parameter int REG_W = 5,
  parameter int WA_W  = 30
) (
  input  logic             ent_vld,
  input  logic [REG_W-1:0] ent_reg,
  input  logic [WA_W-1:0]  ent_wa,
  input  logic [REG_W-1:0] ins_reg,
  input  logic             st_valid,
  input  logic [WA_W-1:0]  st_wa,
  input  logic             chk_valid,
  input  logic [REG_W-1:0] chk_reg,
  output logic             reg_hit,
  output logic             st_hit,
  output logic             chk_hit
);

  always_comb begin
    reg_hit = ent_vld && (ent_reg == ins_reg);
    st_hit  = ent_vld && st_valid && (ent_wa == st_wa);
    chk_hit = ent_vld && chk_valid && (ent_reg == chk_reg);
  end

endmodule

// File: rtl/ldspec_victim.sv
// Picks the slot for an insertion: same register, else free, else round-robin.
module ldspec_victim import ldspec_pkg::*; #(
  parameter int NUM_ENT = 4,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0] ent_vld,
  input  logic [NUM_ENT-1:0] reg_hit,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   sel,
  output pick_e              pick
);

  logic [IDX_W-1:0] same_idx;
  logic [IDX_W-1:0] free_idx;
  logic [NUM_ENT-1:0] free_vec;

  assign free_vec = ~ent_vld;

  always_comb begin
    same_idx = '0;
    free_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (reg_hit[i])  same_idx = IDX_W'(i);
      if (free_vec[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (|reg_hit) begin
      pick = PICK_SAME;
      sel  = same_idx;
    end else if (|free_vec) begin
      pick = PICK_FREE;
      sel  = free_idx;
    end else begin
      pick = PICK_EVICT;
      sel  = rr_ptr;
    end
  end

endmodule

// File: rtl/ldspec_guard.sv
// Table of early-issued loads, cleared by matching stores, queried by check.
module ldspec_guard import ldspec_pkg::*; #(
  parameter int NUM_ENT = 4,
  parameter int REG_W   = 5,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              chk_done,
  output logic              chk_replay
);

  localparam int IDX_W = $clog2(NUM_ENT);
  localparam int WA_W  = ADDR_W - WORD_LSB;

  logic [NUM_ENT-1:0]            ent_vld;
  logic [NUM_ENT-1:0][REG_W-1:0] ent_reg;
  logic [NUM_ENT-1:0][WA_W-1:0]  ent_wa;
  logic [IDX_W-1:0]              rr_q;

  logic [WA_W-1:0]    ins_wa;
  logic [WA_W-1:0]    st_wa;
  logic [NUM_ENT-1:0] reg_hit;
  logic [NUM_ENT-1:0] st_hit;
  logic [NUM_ENT-1:0] chk_hit;
  logic [IDX_W-1:0]   sel;
  pick_e              pick;
  logic               ins_st_hit;
  logic               replay_d;
  logic               unused_lowbits;

  assign ins_wa = ins_addr[ADDR_W-1:WORD_LSB];
  assign st_wa  = st_addr[ADDR_W-1:WORD_LSB];
  assign unused_lowbits = ^{ins_addr[WORD_LSB-1:0], st_addr[WORD_LSB-1:0]};

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    ldspec_cmp #(.REG_W(REG_W), .WA_W(WA_W)) u_cmp (
      .ent_vld  (ent_vld[g]),
      .ent_reg  (ent_reg[g]),
      .ent_wa   (ent_wa[g]),
      .ins_reg  (ins_reg),
      .st_valid (st_valid),
      .st_wa    (st_wa),
      .chk_valid(chk_valid),
      .chk_reg  (chk_reg),
      .reg_hit  (reg_hit[g]),
      .st_hit   (st_hit[g]),
      .chk_hit  (chk_hit[g])
    );
  end

  ldspec_victim #(.NUM_ENT(NUM_ENT)) u_victim (
    .ent_vld(ent_vld),
    .reg_hit(reg_hit),
    .rr_ptr (rr_q),
    .sel    (sel),
    .pick   (pick)
  );

  // A store in the insertion cycle that hits the new word leaves the slot empty.
  assign ins_st_hit = st_valid && (st_wa == ins_wa);

  // Miss, or the hit entry is being killed by a store right now.
  assign replay_d = ~(|chk_hit) | (|(chk_hit & st_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld    <= '0;
      rr_q       <= '0;
      chk_done   <= 1'b0;
      chk_replay <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (ins_valid && (sel == IDX_W'(i))) begin
          ent_vld[i] <= ~ins_st_hit;
          ent_reg[i] <= ins_reg;
          ent_wa[i]  <= ins_wa;
        end else if (st_hit[i] || chk_hit[i]) begin
          ent_vld[i] <= 1'b0;
        end
      end
      if (ins_valid && (pick == PICK_EVICT)) begin
        rr_q <= (rr_q == IDX_W'(NUM_ENT - 1)) ? '0 : rr_q + IDX_W'(1);
      end
      chk_done   <= chk_valid;
      chk_replay <= chk_valid & replay_d;
    end
  end

endmodule

// File: rtl/ldspec_guard_chk.sv
// Property checker attached to ldspec_guard.
module ldspec_guard_chk #(
  parameter int NUM_ENT = 4,
  parameter int REG_W   = 5
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            chk_valid,
  input logic                            chk_done,
  input logic                            chk_replay,
  input logic [NUM_ENT-1:0]              ent_vld,
  input logic [NUM_ENT-1:0][REG_W-1:0]   ent_reg
);

  logic dup_reg;

  always_comb begin
    dup_reg = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      for (int j = i + 1; j < NUM_ENT; j++) begin
        if (ent_vld[i] && ent_vld[j] && (ent_reg[i] == ent_reg[j])) dup_reg = 1'b1;
      end
    end
  end

  a_r1_done_next: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> chk_done);

  a_r1_done_quiet: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !chk_done);

  a_r1_replay_gated: assert property (@(posedge clk) disable iff (rst)
    chk_replay |-> chk_done);

  a_r6_empty_replays: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && (ent_vld == '0)) |=> chk_replay);

  a_r5_unique_reg: assert property (@(posedge clk) disable iff (rst)
    !dup_reg);

  a_r7_one_fill_per_cycle: assert property (@(posedge clk) disable iff (rst)
    $countones(ent_vld) <= $countones($past(ent_vld)) + 1);

endmodule

bind ldspec_guard ldspec_guard_chk #(.NUM_ENT(NUM_ENT), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chk_valid (chk_valid),
  .chk_done  (chk_done),
  .chk_replay(chk_replay),
  .ent_vld   (ent_vld),
  .ent_reg   (ent_reg)
);

// File: tb/tb_ldspec_guard.sv
`timescale 1ns/1ps
module tb_ldspec_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic [4:0]  ins_reg = '0;
  logic [31:0] ins_addr = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic        chk_valid = 1'b0;
  logic [4:0]  chk_reg = '0;
  logic        chk_done;
  logic        chk_replay;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  ldspec_guard dut (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_reg(ins_reg), .ins_addr(ins_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .chk_done(chk_done), .chk_replay(chk_replay)
  );

  typedef struct packed {
    logic        iv;
    logic [4:0]  ir;
    logic [31:0] ia;
    logic        sv;
    logic [31:0] sa;
    logic        cv;
    logic [4:0]  cr;
    logic        rp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t TBL [NV] = '{
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd1, 1'b1,4'd6},  // 0  R6 empty table
    '{1'b1,5'd1,32'h100,  1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd2},  // 1
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd1, 1'b0,4'd2},  // 2  R2 clean
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd1, 1'b1,4'd4},  // 3  R4 consumed
    '{1'b1,5'd2,32'h200,  1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd3},  // 4
    '{1'b0,5'd0,32'h0,    1'b1,32'h203,  1'b0,5'd0, 1'b0,4'd3},  // 5  same word
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd2, 1'b1,4'd3},  // 6  R3 hit
    '{1'b1,5'd3,32'h300,  1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd3},  // 7
    '{1'b0,5'd0,32'h0,    1'b1,32'h304,  1'b0,5'd0, 1'b0,4'd3},  // 8  next word
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd3, 1'b0,4'd3},  // 9  R3 miss
    '{1'b1,5'd4,32'h400,  1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd5},  // 10
    '{1'b1,5'd4,32'h500,  1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd5},  // 11 R5 replace
    '{1'b0,5'd0,32'h0,    1'b1,32'h400,  1'b0,5'd0, 1'b0,4'd5},  // 12 old address
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd4, 1'b0,4'd5},  // 13 R5
    '{1'b1,5'd4,32'h500,  1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd5},  // 14
    '{1'b0,5'd0,32'h0,    1'b1,32'h500,  1'b0,5'd0, 1'b0,4'd5},  // 15 new address
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd4, 1'b1,4'd5},  // 16 R5
    '{1'b1,5'd5,32'h600,  1'b1,32'h602,  1'b0,5'd0, 1'b0,4'd8},  // 17 R8 same cycle
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd5, 1'b1,4'd8},  // 18 R8
    '{1'b1,5'd6,32'h700,  1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd8},  // 19
    '{1'b0,5'd0,32'h0,    1'b1,32'h700,  1'b1,5'd6, 1'b1,4'd8},  // 20 R8 store+check
    '{1'b1,5'd7,32'h800,  1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd10}, // 21
    '{1'b1,5'd7,32'h900,  1'b0,32'h0,    1'b1,5'd7, 1'b0,4'd10}, // 22 R10 old entry
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd7, 1'b0,4'd10}, // 23 R10 new entry
    '{1'b1,5'd8,32'hB00,  1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd3},  // 24
    '{1'b1,5'd9,32'hB01,  1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd3},  // 25
    '{1'b0,5'd0,32'h0,    1'b1,32'hB02,  1'b0,5'd0, 1'b0,4'd3},  // 26 kills both
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd8, 1'b1,4'd3},  // 27 R3
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd9, 1'b1,4'd3},  // 28 R3
    '{1'b1,5'd10,32'hA00, 1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd7},  // 29 slot 0
    '{1'b1,5'd11,32'hA10, 1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd7},  // 30 slot 1
    '{1'b1,5'd12,32'hA20, 1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd7},  // 31 slot 2
    '{1'b1,5'd13,32'hA30, 1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd7},  // 32 slot 3, full
    '{1'b1,5'd14,32'hA40, 1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd7},  // 33 R7 evicts slot 0
    '{1'b1,5'd15,32'hA50, 1'b0,32'h0,    1'b0,5'd0, 1'b0,4'd7},  // 34 R7 evicts slot 1
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd10,1'b1,4'd7},  // 35 R7 displaced
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd11,1'b1,4'd7},  // 36 R7 displaced
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd12,1'b0,4'd7},  // 37
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd13,1'b0,4'd7},  // 38
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd14,1'b0,4'd7},  // 39
    '{1'b0,5'd0,32'h0,    1'b0,32'h0,    1'b1,5'd15,1'b0,4'd7}   // 40
  };

  task automatic check_bit(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    ins_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
    ins_reg = '0; ins_addr = '0; st_addr = '0; chk_reg = '0;
  endtask

  // Drive one vector at a falling edge; the registered answer is read at the next one.
  task automatic apply(input vec_t v, input int idx);
    @(negedge clk);
    ins_valid = v.iv; ins_reg = v.ir; ins_addr = v.ia;
    st_valid = v.sv; st_addr = v.sa;
    chk_valid = v.cv; chk_reg = v.cr;
    @(negedge clk);
    idle_inputs();
    check_bit($sformatf("R1 vec %0d done", idx), chk_done, v.cv);
    if (v.cv)
      check_bit($sformatf("R%0d vec %0d replay", v.req, idx), chk_replay, v.rp);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R9: outputs low while reset is held
    check_bit("R9 reset done", chk_done, 1'b0);
    check_bit("R9 reset replay", chk_replay, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) apply(TBL[k], k);

    // R1: answer lasts one cycle only
    apply('{1'b1,5'd20,32'hC00, 1'b0,32'h0, 1'b1,5'd20, 1'b1,4'd6}, 100);
    @(negedge clk);
    check_bit("R1 done drops", chk_done, 1'b0);
    check_bit("R1 replay drops", chk_replay, 1'b0);

    // R9: reset empties the table
    apply('{1'b1,5'd21,32'hD00, 1'b0,32'h0, 1'b0,5'd0, 1'b0,4'd9}, 101);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    apply('{1'b0,5'd0,32'h0, 1'b0,32'h0, 1'b1,5'd21, 1'b1,4'd9}, 102);

    // R7: pointer restarts at slot 0 after reset
    apply('{1'b1,5'd1,32'h10, 1'b0,32'h0, 1'b0,5'd0, 1'b0,4'd7}, 103);
    apply('{1'b1,5'd2,32'h20, 1'b0,32'h0, 1'b0,5'd0, 1'b0,4'd7}, 104);
    apply('{1'b1,5'd3,32'h30, 1'b0,32'h0, 1'b0,5'd0, 1'b0,4'd7}, 105);
    apply('{1'b1,5'd4,32'h40, 1'b0,32'h0, 1'b0,5'd0, 1'b0,4'd7}, 106);
    apply('{1'b1,5'd5,32'h50, 1'b0,32'h0, 1'b0,5'd0, 1'b0,4'd7}, 107);
    apply('{1'b0,5'd0,32'h0, 1'b0,32'h0, 1'b1,5'd1, 1'b1,4'd7}, 108);
    apply('{1'b0,5'd0,32'h0, 1'b0,32'h0, 1'b1,5'd2, 1'b0,4'd7}, 109);

    finish_run();
  end

endmodule